// File: doc/BRIEF.md
# Clocked Synchronous Serial I/O Unit

This unit moves one byte at a time over a three-wire clocked serial link. A processor write to the data port loads the shift register and starts a transfer. The byte leaves the unit least significant bit first while the unit collects the same number of bits from the serial input. When the transfer is over, the processor reads the received byte from the same data port. A small control register selects the transfer clock source. The source is either a divided copy of the system clock, which the unit drives out on its clock pin, or a clock supplied by the link partner. The partner's clock is brought into the system clock domain through a synchroniser with edge detection.

The unit drives new output data on each falling transfer-clock edge. It samples input data and shifts the register on each rising edge. An interrupt request flag rises after the eighth rising edge and stays up until software writes a zero to it. The two clock sources end a transfer differently. With the internal clock, the clock parks high and the data output is released to high impedance. With the external clock, the output keeps driving the last bit, and any further clock edges keep shifting the register. A ready output tells the partner that an internally clocked transfer is in progress.

The controller has five named states. ST_IDLE waits for a data write. ST_INT_LOW and ST_INT_HIGH are the two halves of an internal clock period. ST_EXT_ACT counts external clocks until the eighth one. ST_EXT_HOLD follows an external transfer that has finished and keeps shifting on any further clocks. The transitions are:
- start_int: ST_IDLE to ST_INT_LOW, on a data write with the internal clock selected.
- start_ext: ST_IDLE to ST_EXT_ACT, on a data write with the external clock selected.
- rise: ST_INT_LOW to ST_INT_HIGH, when the half-period tick fires.
- next_bit: ST_INT_HIGH to ST_INT_LOW, on the tick while bits remain.
- int_done: ST_INT_HIGH to ST_IDLE, on the tick after the last bit.
- ext_done: ST_EXT_ACT to ST_EXT_HOLD, on the eighth synchronised rising edge.
- restart: from any state to ST_INT_LOW or ST_EXT_ACT, on a new data write.

Top module: `csio_unit`

## Requirements
- R1: After reset, sout_oe is 0, irq is 0, sclk_out is 1, rdy is 0 and data_rdata is 0.
- R2: With ctrl_wdata[3]=0 (internal clock), sclk_out spends exactly 2^(2+s) system clocks in each low half and each high half, where s is ctrl_wdata[2:0]. Values 6 and 7 act as 5, so the transfer clock is 1/8, 1/16, 1/32, 1/64, 1/128 or 1/256 of the system clock. The first low half begins on the clock edge that captures the data write.
- R3: sout changes only on falling transfer-clock edges. At the i-th rising edge (i=0..7), sout equals bit i of the written byte.
- R4: Each rising transfer-clock edge samples sin into bit 7 and shifts the register toward bit 0. After eight edges, data_rdata holds the received bits, with the first one in bit 0.
- R5: With the internal clock, exactly eight rising edges occur. irq becomes 1 exactly 16*2^(2+s) clocks after the write edge. At that point sclk_out stays at 1 and sout_oe drops to 0.
- R6: rdy is 1 from the write edge until completion during an internal-clock transfer. rdy is 0 otherwise, including throughout external-clock operation.
- R7: With ctrl_wdata[3]=1 (external clock), irq stays 0 through seven sclk_in periods and becomes 1 after the eighth rising edge. After that, sout_oe stays 1 and sout holds bit 7 of the written byte.
- R8: With the external clock, sclk_in periods after the eighth keep shifting the register and driving sout. These later periods do not set irq again.
- R9: irq_wr with irq_wdata=0 clears irq. irq_wr with irq_wdata=1 leaves irq unchanged.
- R10: A data write during a transfer reloads the register and the 3-bit bit counter (to 7) and starts a complete new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | Write strobe for the data/shift register; starts a transfer |
| data_wdata | input | DATA_W | Byte to transmit |
| data_rdata | output | DATA_W | Current shift register contents |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 4 | Bit 3: 1 = external clock; bits 2:0: divider select |
| irq_wr | input | 1 | Write strobe for the interrupt flag |
| irq_wdata | input | 1 | Value written; only 0 has an effect |
| irq | output | 1 | Interrupt request flag |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock, idle high |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output value |
| sout_oe | output | 1 | Output enable for sout; 0 means high impedance |
| rdy | output | 1 | Ready indication during internal-clock transfers |

## Verification
The bench builds the unit with its default parameters: an 8-bit register, a smallest divide ratio of 8, six ratio settings and a two-stage synchroniser. It sweeps all eight divider select codes, including the two codes that fall back to 1/256, and runs two data patterns per code. Every clock half-period and the completion cycle are predicted arithmetically from the select code. The external-clock runs use a slow partner clock, so the synchroniser delay falls inside each half-period. This makes the D7 hold and the continued shifting beyond the eighth clock directly observable.

// File: rtl/csio_pkg.sv
package csio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INT_LOW,
        ST_INT_HIGH,
        ST_EXT_ACT,
        ST_EXT_HOLD
    } csio_state_e;

endpackage

// File: rtl/csio_sync.sv
module csio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sin,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sin_s
);
    logic [STAGES:0]   sc_q;
    logic [STAGES-1:0] sd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q <= '1;
            sd_q <= '0;
        end else begin
            sc_q <= {sc_q[STAGES-1:0], sclk_in};
            sd_q <= {sd_q[STAGES-2:0], sin};
        end
    end

    assign sclk_rise = sc_q[STAGES-1] & ~sc_q[STAGES];
    assign sclk_fall = ~sc_q[STAGES-1] & sc_q[STAGES];
    assign sin_s     = sd_q[STAGES-1];
endmodule

// File: rtl/csio_clkdiv.sv
module csio_clkdiv #(
    parameter int LOG_MIN = 3,
    parameter int SEL_MAX = 5,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = LOG_MIN - 1 + SEL_MAX;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] term;
    int unsigned   sh;

    always_comb begin
        if (int'(sel) > SEL_MAX) sh = LOG_MIN - 1 + SEL_MAX;
        else                     sh = LOG_MIN - 1 + int'(sel);
        term = CW'((32'd1 << sh) - 32'd1);
    end

    assign tick = run && !clr && (cnt_q == term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (clr || !run || tick)  cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/csio_unit.sv
module csio_unit
    import csio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_LOG_MIN = 3,
    parameter int DIV_SEL_MAX = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    output logic [DATA_W-1:0] data_rdata,
    input  logic              ctrl_wr,
    input  logic [3:0]        ctrl_wdata,
    input  logic              irq_wr,
    input  logic              irq_wdata,
    output logic              irq,
    input  logic              sclk_in,
    output logic              sclk_out,
    input  logic              sin,
    output logic              sout,
    output logic              sout_oe,
    output logic              rdy
);
    localparam int BCW = $clog2(DATA_W);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(DATA_W - 1);

    csio_state_e    state, nxt;
    logic           ext_sel;
    logic [2:0]     div_sel;
    logic [DATA_W-1:0] shreg;
    logic [BCW-1:0] bitcnt;
    logic           tick, s_rise, s_fall, sin_s;
    logic           fin;
    logic           int_run;

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_sel <= 1'b0;
            div_sel <= '0;
        end else if (ctrl_wr) begin
            ext_sel <= ctrl_wdata[3];
            div_sel <= ctrl_wdata[2:0];
        end
    end

    assign int_run = (state == ST_INT_LOW) || (state == ST_INT_HIGH);

    csio_clkdiv #(
        .LOG_MIN (DIV_LOG_MIN),
        .SEL_MAX (DIV_SEL_MAX),
        .SEL_W   (3)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (int_run),
        .clr   (data_wr),
        .sel   (div_sel),
        .tick  (tick)
    );

    csio_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_in),
        .sin       (sin),
        .sclk_rise (s_rise),
        .sclk_fall (s_fall),
        .sin_s     (sin_s)
    );

    // completion of the eighth rising edge in either clock mode
    assign fin = !data_wr && (bitcnt == '0) &&
                 (((state == ST_INT_HIGH) && tick) ||
                  ((state == ST_EXT_ACT) && s_rise));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (data_wr) begin
            nxt = ext_sel ? ST_EXT_ACT : ST_INT_LOW;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_INT_LOW:  if (tick) nxt = ST_INT_HIGH;
                ST_INT_HIGH: if (tick) nxt = (bitcnt == '0) ? ST_IDLE : ST_INT_LOW;
                ST_EXT_ACT:  if (fin) nxt = ST_EXT_HOLD;
                ST_EXT_HOLD: nxt = ST_EXT_HOLD;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bitcnt   <= '0;
            sout     <= 1'b0;
            sclk_out <= 1'b1;
            sout_oe  <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (data_wr) begin
                shreg    <= data_wdata;
                bitcnt   <= BIT_LAST;
                sout_oe  <= 1'b1;
                sclk_out <= ext_sel;
                if (!ext_sel) sout <= data_wdata[0];
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_INT_LOW: begin
                        if (tick) begin
                            sclk_out <= 1'b1;
                            shreg    <= {sin, shreg[DATA_W-1:1]};
                        end
                    end
                    ST_INT_HIGH: begin
                        if (tick) begin
                            if (bitcnt == '0) begin
                                sout_oe <= 1'b0;
                            end else begin
                                bitcnt   <= bitcnt - 1'b1;
                                sclk_out <= 1'b0;
                                sout     <= shreg[0];
                            end
                        end
                    end
                    ST_EXT_ACT, ST_EXT_HOLD: begin
                        if (s_fall) sout <= shreg[0];
                        if (s_rise) begin
                            shreg <= {sin_s, shreg[DATA_W-1:1]};
                            if (bitcnt != '0) bitcnt <= bitcnt - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (fin)                     irq <= 1'b1;
            else if (irq_wr && !irq_wdata) irq <= 1'b0;
        end
    end

    assign data_rdata = shreg;
    assign rdy        = int_run;
endmodule

// File: rtl/csio_chk.sv
module csio_chk
    import csio_pkg::*;
#(
    parameter int BCW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           data_wr,
    input logic           irq_wr,
    input logic           irq_wdata,
    input logic           irq,
    input logic           sclk_out,
    input logic           sout,
    input logic           sout_oe,
    input logic           rdy,
    input csio_state_e    state,
    input logic [BCW-1:0] bitcnt,
    input logic           fin
);
    AST_BITCNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (bitcnt == {BCW{1'b1}}));                                   // R10

    AST_INT_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && state == ST_INT_HIGH) |=> (!sout_oe && sclk_out && irq));       // R5

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> sclk_out);                                       // R5

    AST_SOUT_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT_HIGH && $past(state == ST_INT_HIGH) && !$past(data_wr))
        |-> $stable(sout));                                                     // R3

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_wr && !irq_wdata && !fin) |=> !irq);                               // R9

    AST_RDY_AT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !rdy);                                                   // R6

    AST_HOLD_KEEPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXT_HOLD && !data_wr) |=> sout_oe);                        // R7
endmodule

bind csio_unit csio_chk #(.BCW(BCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (data_wr),
    .irq_wr    (irq_wr),
    .irq_wdata (irq_wdata),
    .irq       (irq),
    .sclk_out  (sclk_out),
    .sout      (sout),
    .sout_oe   (sout_oe),
    .rdy       (rdy),
    .state     (state),
    .bitcnt    (bitcnt),
    .fin       (fin)
);

// File: tb/sim_csio_unit.sv
`timescale 1ns/1ps
module sim_csio_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = '0;
    logic [7:0] data_rdata;
    logic       ctrl_wr = 1'b0;
    logic [3:0] ctrl_wdata = '0;
    logic       irq_wr = 1'b0;
    logic       irq_wdata = 1'b0;
    logic       irq;
    logic       sclk_in = 1'b1;
    logic       sclk_out;
    logic       sin = 1'b0;
    logic       sout;
    logic       sout_oe;
    logic       rdy;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    csio_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr    (data_wr),
        .data_wdata (data_wdata),
        .data_rdata (data_rdata),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .irq_wr     (irq_wr),
        .irq_wdata  (irq_wdata),
        .irq        (irq),
        .sclk_in    (sclk_in),
        .sclk_out   (sclk_out),
        .sin        (sin),
        .sout       (sout),
        .sout_oe    (sout_oe),
        .rdy        (rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic ext, input int sel);
        @(negedge clk);
        ctrl_wr    = 1'b1;
        ctrl_wdata = {ext, 3'(sel)};
        irq_wr     = 1'b1;
        irq_wdata  = 1'b0;
        @(negedge clk);
        ctrl_wr = 1'b0;
        irq_wr  = 1'b0;
    endtask

    task automatic write_data(input logic [7:0] d);
        data_wr    = 1'b1;
        data_wdata = d;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    // internal-clock transfer acting as link partner
    task automatic run_int(input int sel, input logic [7:0] txd, input logic [7:0] rxd);
        int h, fi, ri, terr, rdyerr, irqn;
        logic p;
        logic [7:0] got;
        h = 1 << (2 + ((sel > 5) ? 5 : sel));
        set_ctrl(1'b0, sel);
        write_data(txd);
        p = 1'b1; fi = 0; ri = 0; terr = 0; rdyerr = 0; irqn = -1; got = '0;
        for (int n = 0; n <= 16 * h + 2; n++) begin
            if (n > 0) @(negedge clk);
            if (p && !sclk_out) begin
                if (n != 2 * fi * h) terr++;
                if (fi < 8) sin = rxd[fi];
                fi++;
            end
            if (!p && sclk_out) begin
                if (n != (2 * ri + 1) * h) terr++;
                if (ri < 8) got[ri] = sout;
                ri++;
            end
            if (n < 16 * h && !rdy) rdyerr++;
            if (irq && irqn < 0) irqn = n;
            p = sclk_out;
        end
        chk(terr == 0 && fi == 8 && ri == 8, $sformatf("R2 half-period timing sel=%0d", sel), terr, 0);
        chk(got == txd, $sformatf("R3 bits out sel=%0d", sel), got, txd);
        chk(data_rdata == rxd, $sformatf("R4 received byte sel=%0d", sel), data_rdata, rxd);
        chk(irqn == 16 * h, $sformatf("R5 irq cycle sel=%0d", sel), irqn, 16 * h);
        chk(!sout_oe && sclk_out, $sformatf("R5 released, clock high sel=%0d", sel),
            {sout_oe, sclk_out}, 1);
        chk(rdyerr == 0 && !rdy, $sformatf("R6 rdy window sel=%0d", sel), rdyerr, 0);
    endtask

    task automatic ext_clk(input logic b, output logic s);
        @(negedge clk);
        sclk_in = 1'b0;
        sin     = b;
        repeat (4) @(negedge clk);
        s       = sout;
        sclk_in = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_ext(input logic [7:0] txd, input logic [7:0] rx1, input logic [7:0] rx2);
        logic [7:0] got, got2;
        int rdyerr;
        rdyerr = 0;
        set_ctrl(1'b1, 0);
        write_data(txd);
        for (int i = 0; i < 8; i++) begin
            ext_clk(rx1[i], got[i]);
            if (rdy) rdyerr++;
            if (i == 6) chk(irq == 1'b0, "R7 no irq after seven clocks", irq, 0);
        end
        repeat (2) @(negedge clk);
        chk(irq == 1'b1, "R7 irq after eighth clock", irq, 1);
        chk(sout_oe && sout == txd[7], "R7 output holds D7", {sout_oe, sout}, {1'b1, txd[7]});
        chk(got == txd, "R3 external bits out", got, txd);
        chk(data_rdata == rx1, "R4 external received byte", data_rdata, rx1);
        chk(rdyerr == 0 && !rdy, "R6 rdy low with external clock", rdyerr, 0);
        irq_wr = 1'b1; irq_wdata = 1'b0;
        @(negedge clk);
        irq_wr = 1'b0;
        for (int i = 0; i < 8; i++) ext_clk(rx2[i], got2[i]);
        repeat (2) @(negedge clk);
        chk(got2 == rx1, "R8 continued shifting out", got2, rx1);
        chk(data_rdata == rx2, "R8 continued shifting in", data_rdata, rx2);
        chk(irq == 1'b0, "R8 no second irq", irq, 0);
        chk(sout_oe && sout == rx1[7], "R8 output after extra clocks", sout, rx1[7]);
    endtask

    initial begin
        logic [7:0] a, b;
        repeat (3) @(negedge clk);
        chk(!sout_oe && !irq && sclk_out && !rdy && data_rdata == 8'h00, "R1 reset state",
            {sout_oe, irq, sclk_out, rdy}, 4'b0010);
        rst_n = 1'b1;
        @(negedge clk);
        for (int sel = 0; sel < 8; sel++) begin
            for (int k = 0; k < 2; k++) begin
                a = 8'(8'hA5 ^ (sel * 37) ^ (k * 8'hFF));
                b = 8'({a[2:0], a[7:3]} ^ 8'h3C ^ (k * 8'h81));
                run_int(sel, a, b);
            end
        end
        // R9: clear semantics
        irq_wr = 1'b1; irq_wdata = 1'b1;
        @(negedge clk);
        irq_wr = 1'b0;
        chk(irq == 1'b1, "R9 write of 1 keeps irq", irq, 1);
        irq_wr = 1'b1; irq_wdata = 1'b0;
        @(negedge clk);
        irq_wr = 1'b0;
        chk(irq == 1'b0, "R9 write of 0 clears irq", irq, 0);
        // R10: restart in the middle of a transfer
        set_ctrl(1'b0, 0);
        write_data(8'h3C);
        repeat (20) @(negedge clk);
        chk(irq == 1'b0 && rdy, "R10 first transfer still running", irq, 0);
        run_int(0, 8'hC6, 8'h5A);
        // external clock
        run_ext(8'h96, 8'h4B, 8'hE1);
        run_ext(8'h01, 8'hFE, 8'h80);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule